// File: doc/BRIEF.md
# Multi-Width Serial Link Shifter (Agent Side)

This block is the bit-level link layer of an agent on a chip-select framed serial bus that can run one, two or four data lanes. Everything runs in the bus clock domain. While the host sends a command, the block gathers the incoming lane bits into bytes and presents each byte to the transaction layer with a one-cycle strobe. After the transaction layer requests the turnaround, the block keeps every pin released for one full clock. It then enters the response phase and turns fields from the transaction layer into lane beats.

A response field of 1 to 4 bytes is handed over with a valid/ready handshake, a byte count and a kind tag. The block sends header fields (length, address) starting with the most significant byte. It sends data and status fields starting with the least significant byte. Inputs are sampled on the rising clock edge. Outputs and output enables change on the falling edge. Raising chip select ends the transaction and returns the block to the command phase.

Top module: `espi_link_shifter`

## Requirements
- R1: With mode_i=0 (one lane), receive bits are taken from data_i[0] only, most significant bit first. rx_valid_o pulses for one cycle after the 8th capturing rising edge, and rx_byte_o holds the byte.
- R2: With mode_i=1 (two lanes), each rising edge captures data_i[1] as the higher and data_i[0] as the lower bit of a pair, MSB pair first. A byte completes every 4 clocks.
- R3: With mode_i=2 or 3 (four lanes), each rising edge captures data_i[3:0] as a nibble with data_i[3] highest, upper nibble first. A byte completes every 2 clocks, and rx_valid_o is never high in two consecutive cycles.
- R4: Out of reset and throughout the command phase, data_oe_o is 0. In one-lane mode this keeps pin 1 free for the host.
- R5: When turn_i is high at a rising edge in the command phase, data_oe_o stays 0 until the falling edge that follows the next rising edge. The result is one full clock with all pins released.
- R6: In the response phase, data_oe_o is 4'b0010 in one-lane mode, 4'b0011 in two-lane mode and 4'b1111 in four-lane mode.
- R7: In the response phase, data_o changes on the falling edge. Each byte is sent MSB first on the enabled pins, with the same lane mapping as R1 to R3 (one lane uses pin 1). When no field is being sent, the enabled pins drive 1.
- R8: A field accepted with tx_kind_i=0 (header) sends byte tx_count_i-1 of tx_field_i first and byte 0 last.
- R9: A field accepted with tx_kind_i=1 (data/status) sends byte 0 of tx_field_i first and byte tx_count_i-1 last.
- R10: tx_ready_o is high only in the response phase, when at most one beat of the current field is left to send. A field accepted on the last beat follows with no idle beat in between. A field is accepted on a rising edge where tx_valid_i and tx_ready_o are both high.
- R11: While cs_ni is high, data_oe_o is 0 at once, without waiting for a clock edge. At the next rising edge the phase returns to command, the lane counter clears and any partial receive byte is discarded.
- R12: No rx_valid_o pulse is produced from pin activity during the turnaround or response phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| mode_i | input | 2 | Lane width: 0 one, 1 two, 2/3 four |
| turn_i | input | 1 | Request to end the command phase |
| data_i | input | 4 | Data pin inputs |
| data_o | output | 4 | Data pin output values |
| data_oe_o | output | 4 | Data pin output enables |
| rx_byte_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |
| tx_field_i | input | 32 | Response field, byte 0 in bits 7:0 |
| tx_count_i | input | 3 | Field length in bytes, 1 to 4 |
| tx_kind_i | input | 1 | 0 header, 1 data/status |
| tx_valid_i | input | 1 | Field offered |
| tx_ready_o | output | 1 | Field can be accepted |

## Verification
A wrong lane counter shows up within one byte time as an rx_valid_o strobe on the wrong cycle or a byte with shifted bits. That is at most 8 clocks in one-lane mode. A stale phase register exposes itself on the next falling edge through data_oe_o: pins driven in the command phase, during the turnaround, or left released in the response phase. A wrong transmit byte order or beat count corrupts the very next beat seen on data_o or shifts tx_ready_o. The reference model compares all of these every clock.

// File: rtl/espi_link_pkg.sv
package espi_link_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {MODE_X1 = 2'd0, MODE_X2 = 2'd1, MODE_X4 = 2'd2} io_mode_e;
  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_TURN = 2'd1, PH_RESP = 2'd2} link_phase_e;

  function automatic logic [2:0] lane_bits(logic [1:0] mode);
    case (mode)
      MODE_X1: lane_bits = 3'd1;
      MODE_X2: lane_bits = 3'd2;
      default: lane_bits = 3'd4;
    endcase
  endfunction

  function automatic logic [LANES-1:0] resp_mask(logic [1:0] mode);
    case (mode)
      MODE_X1: resp_mask = 4'b0010;
      MODE_X2: resp_mask = 4'b0011;
      default: resp_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/espi_rx_deser.sv
module espi_rx_deser
  import espi_link_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [LANES-1:0]  pins_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sr_q, sr_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;

  always_comb begin
    case (mode_i)
      MODE_X1: sr_nxt = {sr_q[BYTE_W-2:0], pins_i[0]};
      MODE_X2: sr_nxt = {sr_q[BYTE_W-3:0], pins_i[1:0]};
      default: sr_nxt = {sr_q[BYTE_W-5:0], pins_i[3:0]};
    endcase
    cnt_nxt = cnt_q + CNT_W'(lane_bits(mode_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else if (en_i) begin
      sr_q <= sr_nxt;
      if (cnt_nxt >= CNT_W'(BYTE_W)) begin
        cnt_q   <= '0;
        byte_o  <= sr_nxt;
        valid_o <= 1'b1;
      end else begin
        cnt_q   <= cnt_nxt;
        valid_o <= 1'b0;
      end
    end else begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/espi_tx_ser.sv
module espi_tx_ser
  import espi_link_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           active_i,
  input  logic [1:0]                     mode_i,
  input  logic [MAX_BYTES*BYTE_W-1:0]    field_i,
  input  logic [$clog2(MAX_BYTES+1)-1:0] count_i,
  input  logic                           kind_i,
  input  logic                           valid_i,
  output logic                           ready_o,
  output logic                           busy_o,
  output logic [LANES-1:0]               top_o
);
  localparam int FIELD_W = MAX_BYTES * BYTE_W;
  localparam int BEAT_W  = $clog2(FIELD_W + 1);

  logic [FIELD_W-1:0] ordered, stream_q;
  logic [BEAT_W-1:0]  beats_q, bits_total, beats_load;

  // slot 0 sits at the top of the stream and leaves first
  always_comb begin
    ordered = '0;
    for (int s = 0; s < MAX_BYTES; s++) begin
      int src;
      src = kind_i ? s : int'(count_i) - 1 - s;
      if (s < int'(count_i) && src >= 0 && src < MAX_BYTES)
        ordered[FIELD_W-1-s*BYTE_W -: BYTE_W] = field_i[src*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    bits_total = BEAT_W'(count_i) * BEAT_W'(BYTE_W);
    case (mode_i)
      MODE_X1: beats_load = bits_total;
      MODE_X2: beats_load = bits_total >> 1;
      default: beats_load = bits_total >> 2;
    endcase
  end

  assign ready_o = active_i && (beats_q <= BEAT_W'(1));
  assign busy_o  = (beats_q != '0);
  assign top_o   = stream_q[FIELD_W-1 -: LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stream_q <= '0;
      beats_q  <= '0;
    end else if (clr_i) begin
      stream_q <= '0;
      beats_q  <= '0;
    end else if (active_i) begin
      if (valid_i && ready_o) begin
        stream_q <= ordered;
        beats_q  <= beats_load;
      end else if (busy_o) begin
        stream_q <= stream_q << lane_bits(mode_i);
        beats_q  <= beats_q - BEAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/espi_pin_drv.sv
module espi_pin_drv
  import espi_link_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             resp_i,
  input  logic             busy_i,
  input  logic [1:0]       mode_i,
  input  logic [LANES-1:0] top_i,
  output logic [LANES-1:0] data_o,
  output logic [LANES-1:0] data_oe_o
);
  logic [LANES-1:0] oe_q, d_q, d_nxt;

  always_comb begin
    if (!busy_i) d_nxt = '1;
    else begin
      case (mode_i)
        MODE_X1: d_nxt = {2'b11, top_i[3], 1'b1};
        MODE_X2: d_nxt = {2'b11, top_i[3:2]};
        default: d_nxt = top_i;
      endcase
    end
  end

  // launch on the falling edge so the host samples mid-bit
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q <= '0;
      d_q  <= '1;
    end else begin
      oe_q <= resp_i ? resp_mask(mode_i) : '0;
      d_q  <= d_nxt;
    end
  end

  assign data_o    = d_q;
  assign data_oe_o = oe_q & {LANES{~cs_ni}};
endmodule

// File: rtl/espi_link_shifter.sv
module espi_link_shifter
  import espi_link_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cs_ni,
  input  logic [1:0]                     mode_i,
  input  logic                           turn_i,
  input  logic [LANES-1:0]               data_i,
  output logic [LANES-1:0]               data_o,
  output logic [LANES-1:0]               data_oe_o,
  output logic [BYTE_W-1:0]              rx_byte_o,
  output logic                           rx_valid_o,
  input  logic [MAX_BYTES*BYTE_W-1:0]    tx_field_i,
  input  logic [$clog2(MAX_BYTES+1)-1:0] tx_count_i,
  input  logic                           tx_kind_i,
  input  logic                           tx_valid_i,
  output logic                           tx_ready_o
);
  link_phase_e      phase_q;
  logic             tx_busy;
  logic [LANES-1:0] tx_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= PH_CMD;
    else if (cs_ni) phase_q <= PH_CMD;
    else begin
      case (phase_q)
        PH_CMD:  if (turn_i) phase_q <= PH_TURN;
        PH_TURN: phase_q <= PH_RESP;
        default: phase_q <= PH_RESP;
      endcase
    end
  end

  espi_rx_deser #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cs_ni),
    .en_i    (phase_q == PH_CMD),
    .mode_i  (mode_i),
    .pins_i  (data_i),
    .byte_o  (rx_byte_o),
    .valid_o (rx_valid_o)
  );

  espi_tx_ser #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cs_ni),
    .active_i (phase_q == PH_RESP),
    .mode_i   (mode_i),
    .field_i  (tx_field_i),
    .count_i  (tx_count_i),
    .kind_i   (tx_kind_i),
    .valid_i  (tx_valid_i),
    .ready_o  (tx_ready_o),
    .busy_o   (tx_busy),
    .top_o    (tx_top)
  );

  espi_pin_drv u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .resp_i    (phase_q == PH_RESP),
    .busy_i    (tx_busy),
    .mode_i    (mode_i),
    .top_i     (tx_top),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );
endmodule

// File: rtl/espi_link_chk.sv
module espi_link_chk
  import espi_link_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic [1:0] mode_i,
  input logic [1:0] phase_i,
  input logic [3:0] data_oe_o,
  input logic       rx_valid_o,
  input logic       tx_ready_o
);
  assert_cmd_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_CMD) |-> (data_oe_o == 4'b0000));

  assert_turn_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_TURN) |-> (data_oe_o == 4'b0000));

  assert_single_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_X1) |-> ((data_oe_o & 4'b1101) == 4'b0000));

  assert_ready_resp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (phase_i == PH_RESP));

  assert_cs_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!rx_valid_o && !tx_ready_o));

  assert_no_rx_in_resp_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_RESP) |=> !rx_valid_o);

  assert_rx_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

bind espi_link_shifter espi_link_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .mode_i     (mode_i),
  .phase_i    (phase_q),
  .data_oe_o  (data_oe_o),
  .rx_valid_o (rx_valid_o),
  .tx_ready_o (tx_ready_o)
);

// File: tb/sim_espi_link_shifter.sv
`timescale 1ns/100ps
module sim_espi_link_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        turn = 1'b0;
  logic [3:0]  data_i = 4'h0;
  logic [3:0]  data_o, data_oe;
  logic [7:0]  rx_byte;
  logic        rx_valid;
  logic [31:0] tx_field = '0;
  logic [2:0]  tx_count = 3'd1;
  logic        tx_kind = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  espi_link_shifter u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .mode_i(mode), .turn_i(turn),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
    .tx_field_i(tx_field), .tx_count_i(tx_count), .tx_kind_i(tx_kind),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int         m_phase;
  bit         rxq[$];
  bit         txq[$];
  bit         m_valid;
  logic [7:0] m_byte;

  function automatic int lanes();
    return (mode == 2'd0) ? 1 : (mode == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] rmask();
    return (mode == 2'd0) ? 4'b0010 : (mode == 2'd1) ? 4'b0011 : 4'b1111;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit rdy;
    if (!rst_n) begin
      m_phase = 0; rxq.delete(); txq.delete(); m_valid = 0; m_byte = '0;
    end else if (cs_n) begin
      m_phase = 0; rxq.delete(); txq.delete(); m_valid = 0;
    end else begin
      m_valid = 0;
      case (m_phase)
        0: begin
          for (int i = lanes() - 1; i >= 0; i--) rxq.push_back(data_i[i]);
          if (rxq.size() == 8) begin
            for (int i = 0; i < 8; i++) m_byte[7-i] = rxq[i];
            m_valid = 1;
            rxq.delete();
          end
          if (turn) m_phase = 1;
        end
        1: m_phase = 2;
        default: begin
          rdy = (txq.size() <= lanes());
          for (int i = 0; i < lanes(); i++) if (txq.size() > 0) void'(txq.pop_front());
          if (tx_valid && rdy) begin
            for (int b = 0; b < int'(tx_count); b++) begin
              int idx;
              idx = tx_kind ? b : int'(tx_count) - 1 - b;
              for (int k = 7; k >= 0; k--) txq.push_back(tx_field[idx*8+k]);
            end
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    logic [3:0] exp_oe, exp_d;
    bit exp_rdy;
    #1;
    if (rst_n && run && !done) begin
      exp_oe = (!cs_n && m_phase == 2) ? rmask() : 4'b0000;
      chk(data_oe === exp_oe, (m_phase == 0) ? "R4" : (m_phase == 1) ? "R5" : "R6",
          32'(data_oe), 32'(exp_oe));
      exp_rdy = (m_phase == 2) && (txq.size() <= lanes());
      chk(tx_ready === exp_rdy, "R10", 32'(tx_ready), 32'(exp_rdy));
      chk(rx_valid === m_valid, (m_phase == 2) ? "R12" : (mode == 0) ? "R1" : (mode == 1) ? "R2" : "R3",
          32'(rx_valid), 32'(m_valid));
      if (m_valid)
        chk(rx_byte === m_byte, (mode == 0) ? "R1" : (mode == 1) ? "R2" : "R3",
            32'(rx_byte), 32'(m_byte));
      if (exp_oe != 0) begin
        exp_d = 4'hF;
        if (txq.size() > 0)
          for (int i = 0; i < lanes(); i++) exp_d[(lanes() == 1) ? 1 : lanes()-1-i] = txq[i];
        chk((data_o & exp_oe) === (exp_d & exp_oe), "R7", 32'(data_o & exp_oe), 32'(exp_d & exp_oe));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic rx_send(input logic [7:0] b);
    int w;
    w = lanes();
    for (int k = 0; k < 8 / w; k++) begin
      case (w)
        1: data_i = {3'b000, b[7-k]};
        2: data_i = {2'b00, b[7-2*k -: 2]};
        default: data_i = b[7-4*k -: 4];
      endcase
      cyc(1);
    end
  endtask

  task automatic send(input logic [31:0] v, input int n, input bit k);
    tx_field = v; tx_count = n[2:0]; tx_kind = k; tx_valid = 1'b1;
    while (!tx_ready) cyc(1);
    cyc(1);
    tx_valid = 1'b0;
  endtask

  task automatic watch(input logic [3:0] exp[], input string req);
    #2;
    for (int i = 0; i < exp.size(); i++) begin
      chk(data_o === exp[i], req, 32'(data_o), 32'(exp[i]));
      #4;
    end
    #2;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] hdr_exp[] = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6};
    logic [3:0] dat_exp[] = '{4'hB, 4'h2, 4'hA, 4'h1};
    cyc(2);
    // R4 reset state
    chk(data_oe === 4'b0000, "R4", 32'(data_oe), 0);
    chk(rx_valid === 1'b0, "R1", 32'(rx_valid), 0);
    chk(tx_ready === 1'b0, "R10", 32'(tx_ready), 0);
    rst_n = 1'b1;
    run = 1'b1;
    cyc(2);
    for (int m = 0; m < 3; m++) begin
      mode = m[1:0];
      cyc(1);
      cs_n = 1'b0;
      rx_send(8'hA5);
      rx_send(8'h3C);
      rx_send(8'h81);
      turn = 1'b1; cyc(1); turn = 1'b0;
      data_i = 4'h9;                       // R12 pin noise in response
      if (m == 2) begin
        send(32'h0012_3456, 3, 1'b0);
        watch(hdr_exp, "R8");
        send(32'h0000_A1B2, 2, 1'b1);
        watch(dat_exp, "R9");
      end
      send(32'hDEAD_BEEF, 4, 1'b0);         // R10 back to back
      send(32'h0000_C3E1, 2, 1'b1);
      send(32'h0000_0077, 1, 1'b0);
      cyc(40);
      cs_n = 1'b1;
      #0.5;
      chk(data_oe === 4'b0000, "R11", 32'(data_oe), 0);
      #0.5;
      cyc(2);
      // R11 partial byte dropped on deselect
      cs_n = 1'b0;
      data_i = 4'hF;
      cyc(1);
      cs_n = 1'b1;
      cyc(1);
      cs_n = 1'b0;
      rx_send(8'h5A);
      chk(rx_valid === 1'b1 && rx_byte === 8'h5A, "R11", {23'b0, rx_valid, rx_byte}, 32'h15A);
      cyc(1);
      cs_n = 1'b1;
      cyc(3);
    end
    mode = 2'd3;                            // R3 code 3 acts as four lanes
    cyc(1);
    cs_n = 1'b0;
    rx_send(8'hE7);
    chk(rx_valid === 1'b1 && rx_byte === 8'hE7, "R3", {23'b0, rx_valid, rx_byte}, 32'h1E7);
    cs_n = 1'b1;
    cyc(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule